// File: doc/BRIEF.md
# Tag Subcarrier Reply Waveform Generator

This block produces the load-modulation level of a vicinity-card tag's reply, clocked once per carrier cycle. A start strobe begins a frame. The block emits a start-of-frame delimiter, then one Manchester-coded symbol for each bit it takes from an upstream stream, then an end-of-frame delimiter. Its output is a single level: either a subcarrier square wave or idle low. The analog load switch and any checksum logic live outside the block.

Two selects are sampled when the strobe is taken. The subcarrier select picks one subcarrier (fc/32 against unmodulated time) or two subcarriers (fc/32 against fc/28). The rate select picks the fast rate or the slow rate. At the slow rate every pulse count and every silent span is four times as long, and the subcarrier frequencies do not change.

The upstream source offers bits through valid/ready. The block asks for a bit only at the boundary where the previous symbol ends. If no bit is offered at that boundary, the frame closes with the end-of-frame delimiter. The upstream source must therefore serialize each byte least significant bit first, and it must keep valid high for as long as payload remains.

Top module: `sc_resp_gen`

## Requirements
- R1: After reset, mod_out, frame_done and bit_ready are all low.
- R2: An fc/32 period is 16 cycles high followed by 16 cycles low. An fc/28 period is 14 cycles high followed by 14 cycles low. Every period starts high, and the subcarrier changes only at a period boundary, so each high run lasts exactly 14 or 16 cycles.
- R3: One-subcarrier fast rate: bit 0 is 8 fc/32 periods followed by 256 low cycles. Bit 1 has the same two halves in the opposite order.
- R4: Two-subcarrier fast rate: bit 0 is 8 fc/32 periods followed by 9 fc/28 periods. Bit 1 is 9 fc/28 periods followed by 8 fc/32 periods.
- R5: One-subcarrier delimiters at fast rate. The start is 768 low cycles, then 24 fc/32 periods, then a bit-1 symbol. The end is a bit-0 symbol, then 24 fc/32 periods, then 768 low cycles.
- R6: Two-subcarrier delimiters at fast rate. The start is 27 fc/28 periods, then 24 fc/32 periods, then a bit-1 symbol. The end is a bit-0 symbol, then 24 fc/32 periods, then 27 fc/28 periods.
- R7: With low_rate set at the start strobe, every period count and every low span in R3 to R6 is multiplied by 4.
- R8: The first cycle of the frame is the cycle after the edge that samples start. bit_ready is high only in the last cycle of the start delimiter's bit-1 symbol and in the last cycle of each data symbol. A bit offered in that cycle is sent next. If none is offered, the end delimiter follows.
- R9: frame_done is high for exactly the one cycle after the last cycle of the end delimiter. mod_out is low whenever no frame is active.
- R10: While a frame is active, start, dual_sel and low_rate have no effect on the waveform or on the frame length.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a frame when idle |
| dual_sel | input | 1 | 1 selects two subcarriers, 0 selects one |
| low_rate | input | 1 | 1 selects the slow rate (all durations multiplied by 4) |
| bit_valid | input | 1 | Upstream bit is available |
| bit_data | input | 1 | Upstream bit value |
| bit_ready | output | 1 | Block takes the offered bit in this cycle |
| mod_out | output | 1 | Load-modulation level |
| frame_done | output | 1 | One-cycle end-of-frame flag |

## Verification
The bench sweeps every combination of subcarrier mode and rate. Each frame is compared cycle by cycle against a waveform the bench builds arithmetically from the segment rules.

The payloads are chosen so that each check separates one kind of fault:
- Empty payloads isolate the delimiters from the data symbols.
- Alternating and grouped bit patterns show whether each symbol's half order follows its bit value, and whether bits are taken in stream order.
- Single-bit payloads test the boundary where the first data request coincides with the end of the start delimiter.
- The slow-rate frames show whether the factor of four reaches both the pulse counts and the silent spans.

During every frame the bench also toggles start and both selects. A block that reacts to them produces a different waveform or a different frame length.

// File: rtl/sc_resp_pkg.sv
package sc_resp_pkg;

  typedef enum logic [1:0] {
    SEG_LOW = 2'd0,
    SEG_F32 = 2'd1,
    SEG_F28 = 2'd2
  } seg_kind_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SOF_LEAD,
    ST_SOF_MID,
    ST_SOF_H1,
    ST_SOF_H2,
    ST_BIT_H1,
    ST_BIT_H2,
    ST_EOF_H1,
    ST_EOF_H2,
    ST_EOF_MID,
    ST_EOF_TAIL,
    ST_DONE
  } frm_state_t;

endpackage

// File: rtl/sc_pulse_gen.sv
module sc_pulse_gen
  import sc_resp_pkg::*;
#(
  parameter int unsigned HALF_A = 16,
  parameter int unsigned HALF_B = 14,
  parameter int unsigned CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  seg_kind_t        kind,
  input  logic [CNT_W-1:0] periods,
  output logic             seg_end,
  output logic             mod
);

  localparam int unsigned PER_A   = 2 * HALF_A;
  localparam int unsigned PER_B   = 2 * HALF_B;
  localparam int unsigned PER_MAX = (PER_A > PER_B) ? PER_A : PER_B;
  localparam int unsigned PH_W    = $clog2(PER_MAX);

  logic [PH_W-1:0]  phase_q, phase_d;
  logic [CNT_W-1:0] nper_q, nper_d;
  logic [PH_W-1:0]  last_ph, half_ph;
  logic             period_end;
  logic             cnt_en;

  // Period geometry of the current segment; silent slots use the fc/32 length
  always_comb begin
    if (kind == SEG_F28) begin
      last_ph = PH_W'(PER_B - 1);
      half_ph = PH_W'(HALF_B);
    end else begin
      last_ph = PH_W'(PER_A - 1);
      half_ph = PH_W'(HALF_A);
    end
  end

  assign period_end = active && (phase_q == last_ph);
  assign seg_end    = period_end && (nper_q == (periods - CNT_W'(1)));

  always_comb begin
    phase_d = phase_q;
    nper_d  = nper_q;
    if (!active || seg_end) begin
      phase_d = '0;
      nper_d  = '0;
    end else if (period_end) begin
      phase_d = '0;
      nper_d  = nper_q + CNT_W'(1);
    end else begin
      phase_d = phase_q + PH_W'(1);
    end
  end

  assign cnt_en = active || (phase_q != '0) || (nper_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      nper_q  <= '0;
    end else if (cnt_en) begin
      phase_q <= phase_d;
      nper_q  <= nper_d;
    end
  end

  // Every period opens with its high half, so switching at a boundary keeps phase
  assign mod = active && (kind != SEG_LOW) && (phase_q < half_ph);

endmodule

// File: rtl/sc_frame_seq.sv
module sc_frame_seq
  import sc_resp_pkg::*;
#(
  parameter int unsigned N_HALF32  = 8,
  parameter int unsigned N_HALF28  = 9,
  parameter int unsigned N_DELIM32 = 24,
  parameter int unsigned N_DELIM28 = 27,
  parameter int unsigned N_GAP     = 24,
  parameter int unsigned RATE_MUL  = 4,
  parameter int unsigned CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dual_sel,
  input  logic             low_sel,
  input  logic             bit_valid,
  input  logic             bit_data,
  input  logic             seg_end,
  output logic             bit_ready,
  output logic             active,
  output seg_kind_t        kind,
  output logic [CNT_W-1:0] periods,
  output logic             done
);

  frm_state_t       state_q, state_d;
  logic             dual_q, low_q, bit_q;
  logic             cfg_en, bit_en, st_en;
  seg_kind_t        oth_kind, lead_kind;
  logic [CNT_W-1:0] oth_n, lead_n, base_n;

  // The "other" half of a symbol and the outer delimiter piece depend on the mode
  always_comb begin
    if (dual_q) begin
      oth_kind  = SEG_F28;
      oth_n     = CNT_W'(N_HALF28);
      lead_kind = SEG_F28;
      lead_n    = CNT_W'(N_DELIM28);
    end else begin
      oth_kind  = SEG_LOW;
      oth_n     = CNT_W'(N_HALF32);
      lead_kind = SEG_LOW;
      lead_n    = CNT_W'(N_GAP);
    end
  end

  always_comb begin
    kind   = SEG_LOW;
    base_n = CNT_W'(1);
    unique case (state_q)
      ST_SOF_LEAD, ST_EOF_TAIL: begin kind = lead_kind; base_n = lead_n; end
      ST_SOF_MID, ST_EOF_MID:   begin kind = SEG_F32; base_n = CNT_W'(N_DELIM32); end
      ST_SOF_H1, ST_EOF_H2:     begin kind = oth_kind; base_n = oth_n; end
      ST_SOF_H2, ST_EOF_H1:     begin kind = SEG_F32; base_n = CNT_W'(N_HALF32); end
      ST_BIT_H1: begin
        if (bit_q) begin kind = oth_kind; base_n = oth_n; end
        else       begin kind = SEG_F32;  base_n = CNT_W'(N_HALF32); end
      end
      ST_BIT_H2: begin
        if (bit_q) begin kind = SEG_F32;  base_n = CNT_W'(N_HALF32); end
        else       begin kind = oth_kind; base_n = oth_n; end
      end
      default: begin kind = SEG_LOW; base_n = CNT_W'(1); end
    endcase
  end

  assign periods = low_q ? CNT_W'(base_n * RATE_MUL) : base_n;

  assign active    = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done      = (state_q == ST_DONE);
  assign bit_ready = seg_end && ((state_q == ST_SOF_H2) || (state_q == ST_BIT_H2));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start) state_d = ST_SOF_LEAD;
      ST_SOF_LEAD: if (seg_end) state_d = ST_SOF_MID;
      ST_SOF_MID:  if (seg_end) state_d = ST_SOF_H1;
      ST_SOF_H1:   if (seg_end) state_d = ST_SOF_H2;
      ST_SOF_H2, ST_BIT_H2:
                   if (seg_end) state_d = bit_valid ? ST_BIT_H1 : ST_EOF_H1;
      ST_BIT_H1:   if (seg_end) state_d = ST_BIT_H2;
      ST_EOF_H1:   if (seg_end) state_d = ST_EOF_H2;
      ST_EOF_H2:   if (seg_end) state_d = ST_EOF_MID;
      ST_EOF_MID:  if (seg_end) state_d = ST_EOF_TAIL;
      ST_EOF_TAIL: if (seg_end) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign st_en  = (state_d != state_q);
  assign cfg_en = (state_q == ST_IDLE) && start;
  assign bit_en = bit_ready && bit_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else if (st_en) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dual_q <= 1'b0;
      low_q  <= 1'b0;
    end else if (cfg_en) begin
      dual_q <= dual_sel;
      low_q  <= low_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else if (bit_en) bit_q <= bit_data;
  end

endmodule

// File: rtl/sc_resp_gen.sv
module sc_resp_gen
  import sc_resp_pkg::*;
#(
  parameter int unsigned HALF_A    = 16,
  parameter int unsigned HALF_B    = 14,
  parameter int unsigned N_HALF32  = 8,
  parameter int unsigned N_HALF28  = 9,
  parameter int unsigned N_DELIM32 = 24,
  parameter int unsigned N_DELIM28 = 27,
  parameter int unsigned N_GAP     = 24,
  parameter int unsigned RATE_MUL  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dual_sel,
  input  logic low_rate,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  output logic mod_out,
  output logic frame_done
);

  localparam int unsigned MAX_A   = (N_HALF32 > N_HALF28) ? N_HALF32 : N_HALF28;
  localparam int unsigned MAX_B   = (N_DELIM32 > N_DELIM28) ? N_DELIM32 : N_DELIM28;
  localparam int unsigned MAX_C   = (MAX_B > N_GAP) ? MAX_B : N_GAP;
  localparam int unsigned MAX_N   = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int unsigned CNT_W   = $clog2(MAX_N * RATE_MUL + 1);

  seg_kind_t        seg_kind;
  logic [CNT_W-1:0] seg_periods;
  logic             seg_end;
  logic             seq_active;

  sc_frame_seq #(
    .N_HALF32 (N_HALF32),
    .N_HALF28 (N_HALF28),
    .N_DELIM32(N_DELIM32),
    .N_DELIM28(N_DELIM28),
    .N_GAP    (N_GAP),
    .RATE_MUL (RATE_MUL),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dual_sel (dual_sel),
    .low_sel  (low_rate),
    .bit_valid(bit_valid),
    .bit_data (bit_data),
    .seg_end  (seg_end),
    .bit_ready(bit_ready),
    .active   (seq_active),
    .kind     (seg_kind),
    .periods  (seg_periods),
    .done     (frame_done)
  );

  sc_pulse_gen #(
    .HALF_A(HALF_A),
    .HALF_B(HALF_B),
    .CNT_W (CNT_W)
  ) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (seq_active),
    .kind   (seg_kind),
    .periods(seg_periods),
    .seg_end(seg_end),
    .mod    (mod_out)
  );

endmodule

// File: rtl/sc_resp_gen_chk.sv
module sc_resp_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_ready,
  input logic mod_out,
  input logic frame_done,
  input logic frame_active
);

  // R9: end flag lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R9: no modulation in the flag cycle
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !mod_out);

  // R9: output idle outside a frame
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> !mod_out);

  // R8: bit request is a one-cycle window
  a_r8_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |=> !bit_ready);

  // R8: bits are requested only inside a frame
  a_r8_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> frame_active);

  // R2: a subcarrier high half is never a single cycle
  a_r2_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_out) |=> mod_out);

endmodule

bind sc_resp_gen sc_resp_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_ready   (bit_ready),
  .mod_out     (mod_out),
  .frame_done  (frame_done),
  .frame_active(seq_active)
);

// File: tb/test_sc_resp_gen.sv
module test_sc_resp_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic dual_sel = 1'b0;
  logic low_rate = 1'b0;
  logic bit_valid, bit_data, bit_ready, mod_out, frame_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic fbits [0:15];
  int   fcount = 0;
  int   fidx = 0;
  logic take_pend = 1'b0;

  int sk [0:63];
  int sn [0:63];
  string stag [0:63];
  int nseg;

  always #4 clk = ~clk;

  assign bit_valid = (fidx < fcount);
  assign bit_data  = (fidx < fcount) ? fbits[fidx] : 1'b0;

  sc_resp_gen i_sc_resp_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .dual_sel(dual_sel),
    .low_rate(low_rate), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .mod_out(mod_out), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Upstream bit source: advances after each accepted bit
  initial begin
    forever begin
      @(negedge clk);
      if (take_pend) fidx++;
      take_pend = bit_ready && bit_valid;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic add_seg(input int k, input int n, input string t);
    sk[nseg] = k; sn[nseg] = n; stag[nseg] = t; nseg++;
  endtask

  // Kinds: 0 silent 32-cycle slot, 1 fc/32 period, 2 fc/28 period
  task automatic add_sym(input bit b, input bit dual, input int m, input string t);
    int ok_k = dual ? 2 : 0;
    int ok_n = dual ? 9 : 8;
    if (b) begin add_seg(ok_k, ok_n * m, t); add_seg(1, 8 * m, t); end
    else   begin add_seg(1, 8 * m, t); add_seg(ok_k, ok_n * m, t); end
  endtask

  task automatic run_frame(input bit dual, input bit low, input int nb, input logic [15:0] pat);
    int m = low ? 4 : 1;
    string dtag = low ? "R7" : (dual ? "R4" : "R3");
    string ftag = low ? "R7" : (dual ? "R6" : "R5");
    int fc = 0;
    int run = 0;
    int badrun = 0;
    logic prev = 1'b0;
    nseg = 0;
    add_seg(dual ? 2 : 0, (dual ? 27 : 24) * m, ftag);
    add_seg(1, 24 * m, ftag);
    add_sym(1'b1, dual, m, ftag);
    for (int i = 0; i < nb; i++) add_sym(pat[i], dual, m, dtag);
    add_sym(1'b0, dual, m, ftag);
    add_seg(1, 24 * m, ftag);
    add_seg(dual ? 2 : 0, (dual ? 27 : 24) * m, ftag);
    for (int i = 0; i < nb; i++) fbits[i] = pat[i];
    @(negedge clk);
    fidx = 0; fcount = nb;
    start = 1'b1; dual_sel = dual; low_rate = low;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < nseg; s++) begin
      int miss = 0;
      int first_bad = -1;
      int len = (sk[s] == 2) ? 28 : 32;
      for (int p = 0; p < sn[s]; p++) begin
        for (int ph = 0; ph < len; ph++) begin
          logic e = (sk[s] != 0) && (ph < len / 2);
          if (fc > 0) @(negedge clk);
          // R10: disturb controls mid-frame
          if (fc == 50) begin start = 1'b1; dual_sel = ~dual; low_rate = ~low; end
          if (fc == 51) begin start = 1'b0; dual_sel = dual; low_rate = low; end
          if (mod_out !== e) begin miss++; if (first_bad < 0) first_bad = fc; end
          if (mod_out === 1'b1) run++;
          else begin
            if (prev === 1'b1 && run != 14 && run != 16) badrun++;
            run = 0;
          end
          prev = mod_out;
          fc++;
        end
      end
      chk(miss == 0, stag[s], miss, 0);
    end
    @(negedge clk);
    chk(frame_done === 1'b1 && mod_out === 1'b0, "R9 done after end delimiter (R10 length)",
        int'(frame_done), 1);
    chk(badrun == 0 && !(prev === 1'b1 && run != 14 && run != 16), "R2 high run widths", badrun, 0);
    @(negedge clk);
    chk(frame_done === 1'b0 && mod_out === 1'b0, "R9 done single cycle", int'(frame_done), 0);
    chk(fidx == nb, "R8 bits consumed", fidx, nb);
  endtask

  initial begin
    #1;
    chk(mod_out === 1'b0 && frame_done === 1'b0 && bit_ready === 1'b0, "R1 reset outputs",
        int'(mod_out) + int'(frame_done) + int'(bit_ready), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mod_out === 1'b0 && frame_done === 1'b0, "R1 idle after reset",
        int'(mod_out) + int'(frame_done), 0);
    run_frame(1'b0, 1'b0, 0, 16'h0000);
    run_frame(1'b0, 1'b0, 8, 16'h00A5);
    run_frame(1'b1, 1'b0, 0, 16'h0000);
    run_frame(1'b1, 1'b0, 8, 16'h003C);
    run_frame(1'b0, 1'b0, 1, 16'h0001);
    run_frame(1'b1, 1'b0, 1, 16'h0000);
    run_frame(1'b0, 1'b1, 2, 16'h0001);
    run_frame(1'b1, 1'b1, 2, 16'h0002);
    repeat (40) @(negedge clk);
    chk(mod_out === 1'b0 && bit_ready === 1'b0, "R9 idle between frames", int'(mod_out), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule